// File: doc/BRIEF.md
# Descriptor-Driven I/O Command Processor

This block is a small I/O processor that takes data transfers off a host CPU. The host writes the word address of a command list and then a start strobe over a simple register port. From then on the block walks the list by itself. It reads each four-word descriptor from memory and moves the requested number of words between a device port and memory. On request it reverses the byte order of each word on the way out. When the list ends, it raises an interrupt.

Memory is shared with the CPU. The block takes cycles from it through a request/grant handshake. Every descriptor read and every data access waits for a grant. Read data returns on the cycle after the grant.

A descriptor is four consecutive words. Word 0 holds the opcode in bits [7:0] and a last-in-list flag in bit 31. Word 1 holds the device address. Word 2 holds the memory word address. The low CW bits of word 3 hold the word count. Without the last flag, the next descriptor starts four words further on. Opcodes are:
- 0: device to memory.
- 1: memory to device.
- 2: memory to device with byte swap.
- 3: no operation.

Top module: `iop_core`

## Requirements
- R1: After reset the block is idle (busy_o low): no memory request, no device strobe, irq_o and err_o low.
- R2: A start (write to select 1 with bit 0 set) while idle fetches the four descriptor words from the list pointer (select 0) onward, in ascending word addresses. A start while busy is ignored, and the current list runs unchanged.
- R3: mem_req_o, once raised, stays high with mem_addr_o, mem_we_o and mem_wdata_o unchanged until mem_gnt_i is seen high.
- R4: Opcode 0 reads count words from the device address (dev_rd_o, data sampled the same cycle). It writes them to memory at the descriptor's memory address, +1, +2, and so on.
- R5: Opcode 1 reads count words from memory at ascending addresses and writes each unchanged to the device address with dev_wr_o.
- R6: Opcode 2 acts as opcode 1, except that each word reaches the device with its byte order reversed (byte 0 becomes byte 3).
- R7: Opcode 3, or any descriptor whose count is zero, completes with no device strobe and no memory data access.
- R8: A descriptor with bit 31 of word 0 set ends the list. Otherwise the next descriptor is fetched at the current descriptor address + 4.
- R9: An opcode above 3 stops the list with no data cycles for that descriptor. No later descriptor is fetched, and both err_o and irq_o are set.
- R10: irq_o stays high after a list ends until the host writes to select 2 with bit 0 set. err_o clears only on a write to select 2 with bit 1 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Host register write strobe |
| reg_sel_i | input | 2 | Register select: 0 list pointer, 1 control, 2 status clear |
| reg_wdata_i | input | AW | Host write data |
| busy_o | output | 1 | List in progress |
| irq_o | output | 1 | Interrupt, list finished |
| err_o | output | 1 | Invalid opcode seen |
| mem_req_o | output | 1 | Memory cycle request |
| mem_gnt_i | input | 1 | Memory cycle grant |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdata_i | input | DW | Memory read data, valid the cycle after grant |
| dev_rd_o | output | 1 | Device read strobe |
| dev_wr_o | output | 1 | Device write strobe |
| dev_addr_o | output | AW | Device address from descriptor |
| dev_wdata_o | output | DW | Device write data |
| dev_rdata_i | input | DW | Device read data, sampled with dev_rd_o |

## Verification
Single and chained lists are each run under three grant patterns: always granted, every other cycle, and every third cycle. Comparing them shows that sequencing waits for the grant rather than counting cycles. A chain of a plain and a swapping memory-to-device descriptor separates the byte-swap path from the plain path, and shows that the fetch moves four words on. Lists mixing no-op, zero-count and one-word descriptors tell skipped data cycles apart from executed ones. A list with a bad opcode ahead of a valid descriptor shows that the list stops early. A start issued mid-transfer shows that a busy start is ignored.

// File: rtl/iop_pkg.sv
package iop_pkg;
  localparam logic [1:0] SEL_PTR  = 2'd0;
  localparam logic [1:0] SEL_CTRL = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;

  localparam logic [7:0] OP_D2M  = 8'd0;
  localparam logic [7:0] OP_M2D  = 8'd1;
  localparam logic [7:0] OP_M2DS = 8'd2;
  localparam logic [7:0] OP_NOP  = 8'd3;

  localparam int DESC_WORDS = 4;

  typedef enum logic [3:0] {
    S_IDLE, S_FREQ, S_FWAIT, S_DEC, S_DRD, S_DWR,
    S_MREQ, S_MWAIT, S_MWR, S_NEXT, S_FIN, S_ERR
  } seq_state_e;
endpackage

// File: rtl/iop_regs.sv
module iop_regs
  import iop_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [1:0]    sel_i,
  input  logic [AW-1:0] wdata_i,
  input  logic          fin_i,
  input  logic          err_i,
  output logic [AW-1:0] list_ptr_o,
  output logic          start_o,
  output logic          done_o,
  output logic          err_o
);
  logic clr_done, clr_err;

  assign start_o  = wr_i && (sel_i == SEL_CTRL) && wdata_i[0];
  assign clr_done = wr_i && (sel_i == SEL_STAT) && wdata_i[0];
  assign clr_err  = wr_i && (sel_i == SEL_STAT) && wdata_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      list_ptr_o <= '0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      if (wr_i && sel_i == SEL_PTR) list_ptr_o <= wdata_i;
      // set wins over a same-cycle clear
      if (fin_i)         done_o <= 1'b1;
      else if (clr_done) done_o <= 1'b0;
      if (err_i)         err_o  <= 1'b1;
      else if (clr_err)  err_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/iop_swap.sv
module iop_swap #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] dout_o
);
  localparam int NB = DW / 8;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign dout_o[8*b +: 8] = din_i[8*(NB-1-b) +: 8];
  end
endmodule

// File: rtl/iop_seq.sv
module iop_seq
  import iop_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] list_ptr_i,
  output logic          busy_o,
  output logic          fin_o,
  output logic          err_o,
  output logic          mem_req_o,
  input  logic          mem_gnt_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          dev_rd_o,
  output logic          dev_wr_o,
  output logic [AW-1:0] dev_addr_o,
  output logic [DW-1:0] dev_wdata_o,
  input  logic [DW-1:0] dev_rdata_i
);
  localparam int IW = $clog2(DESC_WORDS);

  seq_state_e    state_q;
  logic [IW-1:0] idx_q;
  logic [AW-1:0] desc_addr_q, mem_ptr_q;
  logic [CW-1:0] rem_q;
  logic [DW-1:0] data_q, swapped;
  logic [DW-1:0] desc_q [DESC_WORDS];

  logic [7:0]    op;
  logic          last;
  logic [CW-1:0] cnt;
  logic          unused_bits;

  assign op   = desc_q[0][7:0];
  assign last = desc_q[0][DW-1];
  assign cnt  = desc_q[3][CW-1:0];
  assign unused_bits = ^{desc_q[0][DW-2:8], desc_q[3][DW-1:CW]};

  iop_swap #(.DW(DW)) u_swap (.din_i(mem_rdata_i), .dout_o(swapped));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      idx_q       <= '0;
      desc_addr_q <= '0;
      mem_ptr_q   <= '0;
      rem_q       <= '0;
      data_q      <= '0;
      for (int i = 0; i < DESC_WORDS; i++) desc_q[i] <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          desc_addr_q <= list_ptr_i;
          idx_q       <= '0;
          state_q     <= S_FREQ;
        end
        S_FREQ: if (mem_gnt_i) state_q <= S_FWAIT;
        S_FWAIT: begin
          desc_q[idx_q] <= mem_rdata_i;
          idx_q         <= idx_q + 1'b1;
          state_q       <= (idx_q == IW'(DESC_WORDS-1)) ? S_DEC : S_FREQ;
        end
        S_DEC: begin
          mem_ptr_q <= desc_q[2][AW-1:0];
          rem_q     <= cnt;
          if (op > OP_NOP)                     state_q <= S_ERR;
          else if (op == OP_NOP || cnt == '0)  state_q <= S_NEXT;
          else if (op == OP_D2M)               state_q <= S_DRD;
          else                                 state_q <= S_MREQ;
        end
        S_DRD: begin
          data_q  <= dev_rdata_i;
          state_q <= S_DWR;
        end
        S_DWR: if (mem_gnt_i) begin
          mem_ptr_q <= mem_ptr_q + 1'b1;
          rem_q     <= rem_q - 1'b1;
          state_q   <= (rem_q == CW'(1)) ? S_NEXT : S_DRD;
        end
        S_MREQ: if (mem_gnt_i) state_q <= S_MWAIT;
        S_MWAIT: begin
          data_q  <= (op == OP_M2DS) ? swapped : mem_rdata_i;
          state_q <= S_MWR;
        end
        S_MWR: begin
          mem_ptr_q <= mem_ptr_q + 1'b1;
          rem_q     <= rem_q - 1'b1;
          state_q   <= (rem_q == CW'(1)) ? S_NEXT : S_MREQ;
        end
        S_NEXT: begin
          idx_q <= '0;
          if (last) state_q <= S_FIN;
          else begin
            desc_addr_q <= desc_addr_q + AW'(DESC_WORDS);
            state_q     <= S_FREQ;
          end
        end
        S_FIN, S_ERR: state_q <= S_IDLE;
        default:      state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o  = 1'b0;
    mem_we_o   = 1'b0;
    mem_addr_o = mem_ptr_q;
    unique case (state_q)
      S_FREQ: begin
        mem_req_o  = 1'b1;
        mem_addr_o = desc_addr_q + AW'(idx_q);
      end
      S_DWR: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
      end
      S_MREQ:  mem_req_o = 1'b1;
      default: ;
    endcase
  end

  assign mem_wdata_o = data_q;
  assign dev_wdata_o = data_q;
  assign dev_addr_o  = desc_q[1][AW-1:0];
  assign dev_rd_o    = (state_q == S_DRD);
  assign dev_wr_o    = (state_q == S_MWR);
  assign busy_o      = (state_q != S_IDLE);
  assign fin_o       = (state_q == S_FIN) || (state_q == S_ERR);
  assign err_o       = (state_q == S_ERR);
endmodule

// File: rtl/iop_core.sv
module iop_core
  import iop_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_wr_i,
  input  logic [1:0]    reg_sel_i,
  input  logic [AW-1:0] reg_wdata_i,
  output logic          busy_o,
  output logic          irq_o,
  output logic          err_o,
  output logic          mem_req_o,
  input  logic          mem_gnt_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          dev_rd_o,
  output logic          dev_wr_o,
  output logic [AW-1:0] dev_addr_o,
  output logic [DW-1:0] dev_wdata_o,
  input  logic [DW-1:0] dev_rdata_i
);
  logic [AW-1:0] list_ptr;
  logic          start, fin, err_hit;

  iop_regs #(.AW(AW)) u_regs (
    .clk_i, .rst_ni,
    .wr_i(reg_wr_i), .sel_i(reg_sel_i), .wdata_i(reg_wdata_i),
    .fin_i(fin), .err_i(err_hit),
    .list_ptr_o(list_ptr), .start_o(start),
    .done_o(irq_o), .err_o(err_o)
  );

  iop_seq #(.AW(AW), .DW(DW), .CW(CW)) u_seq (
    .clk_i, .rst_ni,
    .start_i(start), .list_ptr_i(list_ptr),
    .busy_o, .fin_o(fin), .err_o(err_hit),
    .mem_req_o, .mem_gnt_i, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_rdata_i,
    .dev_rd_o, .dev_wr_o, .dev_addr_o, .dev_wdata_o, .dev_rdata_i
  );
endmodule

// File: rtl/iop_core_chk.sv
module iop_core_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reg_wr_i,
  input logic [1:0]    reg_sel_i,
  input logic [AW-1:0] reg_wdata_i,
  input logic          busy_o,
  input logic          irq_o,
  input logic          err_o,
  input logic          mem_req_o,
  input logic          mem_gnt_i,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          dev_rd_o,
  input logic          dev_wr_o
);
  logic clr_done;
  assign clr_done = reg_wr_i && (reg_sel_i == 2'd2) && reg_wdata_i[0];

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o && !dev_rd_o && !dev_wr_o);

  p_req_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o)
                                && $stable(mem_we_o) && $stable(mem_wdata_o));

  p_one_port_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({mem_req_o, dev_rd_o, dev_wr_o}) <= 1);

  p_end_from_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(busy_o) && !busy_o);

  p_err_raises_irq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> irq_o);

  p_irq_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !clr_done |=> irq_o);
endmodule

bind iop_core iop_core_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .reg_wr_i(reg_wr_i), .reg_sel_i(reg_sel_i), .reg_wdata_i(reg_wdata_i),
  .busy_o(busy_o), .irq_o(irq_o), .err_o(err_o),
  .mem_req_o(mem_req_o), .mem_gnt_i(mem_gnt_i), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
  .dev_rd_o(dev_rd_o), .dev_wr_o(dev_wr_o)
);

// File: tb/iop_core_test.sv
module iop_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          reg_wr = 1'b0;
  logic [1:0]    reg_sel = '0;
  logic [AW-1:0] reg_wdata = '0;
  logic          busy, irq, err;
  logic          mem_req, mem_gnt, mem_we;
  logic [AW-1:0] mem_addr, dev_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, dev_wdata, dev_rdata;
  logic          dev_rd, dev_wr;

  iop_core #(.AW(AW), .DW(DW), .CW(16)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .reg_wr_i(reg_wr), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .busy_o(busy), .irq_o(irq), .err_o(err),
    .mem_req_o(mem_req), .mem_gnt_i(mem_gnt), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .dev_rd_o(dev_rd), .dev_wr_o(dev_wr), .dev_addr_o(dev_addr),
    .dev_wdata_o(dev_wdata), .dev_rdata_i(dev_rdata)
  );

  // memory and device models
  logic [31:0] mem [256];
  logic [31:0] rdata_q = '0;
  int          gnt_mode = 0;
  int unsigned cyc = 0;
  logic        clr = 1'b0;
  logic        pl_we = 1'b0;
  logic [7:0]  pl_addr = '0;
  logic [31:0] pl_data = '0;
  int n_mrd, n_mwr, n_drd, n_dwr, viol;
  logic [7:0]  rd_log [16];
  logic [31:0] dwr_log [32];
  logic [7:0]  dwr_addr0;
  logic        prev_wait = 1'b0;
  logic [31:0] prev_addr = '0;

  assign mem_rdata = rdata_q;
  assign mem_gnt = (gnt_mode == 0) ? 1'b1 :
                   (gnt_mode == 1) ? cyc[0] : ((cyc % 3) == 0);
  assign dev_rdata = {8'hD0, dev_addr[7:0], 8'h00, n_drd[7:0]};

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (pl_we) mem[pl_addr] <= pl_data;
    if (mem_req && mem_gnt) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      else rdata_q <= mem[mem_addr[7:0]];
    end
    prev_wait <= mem_req && !mem_gnt;
    prev_addr <= mem_addr;
    if (clr) begin
      n_mrd <= 0; n_mwr <= 0; n_drd <= 0; n_dwr <= 0; viol <= 0;
    end else begin
      if (prev_wait && (!mem_req || mem_addr != prev_addr)) viol <= viol + 1;
      if (mem_req && mem_gnt && !mem_we) begin
        if (n_mrd < 16) rd_log[n_mrd] <= mem_addr[7:0];
        n_mrd <= n_mrd + 1;
      end
      if (mem_req && mem_gnt && mem_we) n_mwr <= n_mwr + 1;
      if (dev_rd) n_drd <= n_drd + 1;
      if (dev_wr) begin
        if (n_dwr < 32) dwr_log[n_dwr] <= dev_wdata;
        if (n_dwr == 0) dwr_addr0 <= dev_addr[7:0];
        n_dwr <= n_dwr + 1;
      end
    end
  end

  int checks = 0, failures = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(logic [7:0] a, logic [31:0] d);
    @(negedge clk); pl_we = 1'b1; pl_addr = a; pl_data = d;
    @(negedge clk); pl_we = 1'b0;
  endtask

  task automatic desc(logic [7:0] a, logic [31:0] w0, logic [31:0] w1,
                      logic [31:0] w2, logic [31:0] w3);
    poke(a, w0); poke(a + 8'd1, w1); poke(a + 8'd2, w2); poke(a + 8'd3, w3);
  endtask

  task automatic host_wr(logic [1:0] sel, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic clear_counts();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic run(logic [7:0] ptr);
    clear_counts();
    host_wr(2'd0, {24'd0, ptr});
    host_wr(2'd1, 32'd1);
  endtask

  task automatic wait_irq(string tag);
    int n = 0;
    while (!irq && n < 3000) begin @(negedge clk); n++; end
    check({tag, " list completes"}, {31'd0, irq}, 32'd1);
  endtask

  function automatic logic [31:0] bswap(logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 err", {31'd0, err}, 32'd0);
    check("R1 req", {29'd0, mem_req, dev_rd, dev_wr}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 idle after release", {30'd0, busy, mem_req}, 32'd0);

    for (int g = 0; g < 3; g++) begin
      gnt_mode = g;
      // single device-to-memory descriptor
      desc(8'h10, 32'h8000_0000, 32'd5, 32'h40, 32'd3);
      run(8'h10);
      wait_irq("R4");
      for (int i = 0; i < 4; i++)
        check("R2 fetch address", {24'd0, rd_log[i]}, 32'h10 + i);
      for (int i = 0; i < 3; i++)
        check("R4 mem word", mem[8'h40 + i], {8'hD0, 8'h05, 8'h00, 8'(i)});
      check("R4 device reads", n_drd, 32'd3);
      check("R3 request held", viol, 32'd0);
      check("R10 idle with irq", {31'd0, busy}, 32'd0);
      repeat (3) @(negedge clk);
      check("R10 irq held", {31'd0, irq}, 32'd1);
      host_wr(2'd2, 32'd1);
      check("R10 irq cleared", {31'd0, irq}, 32'd0);

      // chained plain and swapping memory-to-device
      for (int i = 0; i < 8; i++)
        poke(8'h60 + 8'(i), {8'h10 + 8'(i), 8'h20, 8'h30, 8'h40 + 8'(i)});
      desc(8'h20, 32'h0000_0001, 32'd3, 32'h60, 32'd4);
      desc(8'h24, 32'h8000_0002, 32'd3, 32'h64, 32'd4);
      run(8'h20);
      wait_irq("R8");
      check("R8 second descriptor address", {24'd0, rd_log[8]}, 32'h24);
      check("R5 device writes", n_dwr, 32'd8);
      check("R5 device address", {24'd0, dwr_addr0}, 32'd3);
      for (int i = 0; i < 4; i++)
        check("R5 plain word", dwr_log[i], {8'h10 + 8'(i), 8'h20, 8'h30, 8'h40 + 8'(i)});
      for (int i = 4; i < 8; i++)
        check("R6 swapped word", dwr_log[i],
              bswap({8'h10 + 8'(i), 8'h20, 8'h30, 8'h40 + 8'(i)}));
      check("R3 request held chain", viol, 32'd0);
      host_wr(2'd2, 32'd1);
    end

    // no-op and zero count skip data cycles
    gnt_mode = 1;
    poke(8'h70, 32'hCAFE_0001);
    desc(8'h30, 32'h0000_0003, 32'd1, 32'h50, 32'd5);
    desc(8'h34, 32'h0000_0000, 32'd1, 32'h50, 32'd0);
    desc(8'h38, 32'h8000_0001, 32'd1, 32'h70, 32'd1);
    run(8'h30);
    wait_irq("R7");
    check("R7 device writes", n_dwr, 32'd1);
    check("R7 device reads", n_drd, 32'd0);
    check("R7 memory writes", n_mwr, 32'd0);
    check("R7 memory reads", n_mrd, 32'd13);
    check("R7 word", dwr_log[0], 32'hCAFE_0001);
    host_wr(2'd2, 32'd1);

    // invalid opcode stops the list
    desc(8'h90, 32'h0000_0003, 32'd1, 32'h50, 32'd0);
    desc(8'h94, 32'h0000_0007, 32'd1, 32'h50, 32'd2);
    desc(8'h98, 32'h8000_0001, 32'd1, 32'h70, 32'd1);
    run(8'h90);
    wait_irq("R9");
    check("R9 err set", {31'd0, err}, 32'd1);
    check("R9 descriptor reads", n_mrd, 32'd8);
    check("R9 no data cycles", n_drd + n_dwr + n_mwr, 32'd0);
    host_wr(2'd2, 32'd2);
    check("R10 err cleared", {31'd0, err}, 32'd0);
    check("R10 irq kept by err clear", {31'd0, irq}, 32'd1);
    host_wr(2'd2, 32'd1);
    check("R10 irq cleared after err", {31'd0, irq}, 32'd0);

    // start while busy is ignored
    desc(8'hA0, 32'h8000_0000, 32'd2, 32'hB0, 32'd8);
    run(8'hA0);
    repeat (6) @(negedge clk);
    check("R2 busy mid list", {31'd0, busy}, 32'd1);
    host_wr(2'd0, 32'h30);
    host_wr(2'd1, 32'd1);
    wait_irq("R2");
    check("R2 single fetch", n_mrd, 32'd4);
    check("R2 device reads", n_drd, 32'd8);
    check("R2 memory writes", n_mwr, 32'd8);
    check("R4 last word", mem[8'hB7], {8'hD0, 8'h02, 8'h00, 8'd7});
    repeat (10) @(negedge clk);
    check("R2 no restart", {31'd0, busy}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule